// File: doc/BRIEF.md
# Sixteen-Bit Up-Counter with Capture/Compare Channels and Overflow Flag

This block is a 16-bit up-counter with two channel registers. Each channel register works as a compare register or as a capture register. An 8-bit option register holds the capture/compare choice for each channel and a sticky wrap flag. The counter runs while the enable input is high and is held at zero while it is low. A 2-bit mode input picks one of four modes:

- interval (0): the counter restarts from zero after it equals channel 0.
- free-running (1).
- pulse-width (2).
- reserved (3): the counter counts freely.

Software reaches the registers through a byte-wide bus. A write carries an 8-bit mask, and only the bits whose mask bit is 1 are changed. Reads are combinational on the address. The address map is:

- 0: option register.
- 1 and 2: channel 0, low byte then high byte.
- 3 and 4: channel 1, low byte then high byte.
- 5 and 6: counter, low byte then high byte.
- Any other address reads 0x00.

The wrap flag sets only in the free-running and pulse-width modes. A one-cycle interrupt pulse is raised in the same cycle that the flag sets. Software can clear the flag but cannot set it.

Top module: `tmr16_ccsel`

## Requirements
- R1: After reset, the option register reads 0x00. The counter and both channel registers read 0. ovf_irq_o and match_o are 0.
- R2: Bits 7, 6, 3, 2 and 1 of the option register always read 0, whatever was written to them.
- R3: When the counter steps from 0xFFFF to 0x0000 with mode 1 or 2, flag bit 0 of the option register becomes 1 and ovf_irq_o is high for exactly one cycle, both in the cycle after that edge. In modes 0 and 3 the same step changes neither.
- R4: The flag clears when a masked write to address 0 writes 0 to bit 0, or on the edge after the enable is seen low. Reading the flag never clears it.
- R5: A write of 1 to bit 0 of the option register leaves the flag unchanged.
- R6: If a wrap and a write of 0 to the flag fall on the same edge, the flag is 1 afterwards.
- R7: Bit 4 selects channel 0 and bit 5 selects channel 1 (0 = compare, 1 = capture). These bits take masked writes only while the enable is low. Writes to them while the enable is high are ignored.
- R8: match_o[i] is high while the enable is high, channel i acts as a compare register, and the counter equals that channel's register.
- R9: A channel acts as a capture register only when its select bit is 1 and the mode is 1. In that case, a rising edge on capture_i[i] loads the counter value current at that edge. A channel whose select bit is 1 clears to 0 while the enable is low and ignores bus writes. A channel whose select bit is 0 takes masked byte writes.
- R10: The counter holds 0 while the enable is low and otherwise adds 1 per cycle. A byte write to address 5 or 6 replaces that byte, and takes priority over counting. In mode 0 the counter goes to 0 after equalling channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Counter enable |
| mode_i | input | 2 | Operating mode (0 interval, 1 free-running, 2 pulse-width, 3 reserved) |
| capture_i | input | 2 | Capture trigger per channel, rising-edge sensitive |
| bus_addr_i | input | 3 | Register address for read and write |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_wmask_i | input | 8 | Per-bit write mask |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| match_o | output | 2 | Compare match per channel |
| ovf_irq_o | output | 1 | One-cycle wrap interrupt |

## Verification
The bench goes after the wrap edge in each mode:
- A design that raised the flag in interval mode fails the wrap checks.
- A design that issued the pulse a cycle early or late fails the same checks.

It lands a clear-flag write exactly on the wrap edge. A design that let the clear win would show the flag at 0.

It tries to set the flag by writing 1 and to flip the select bits while the counter is enabled. A design that accepted either would read back a changed option byte.

It checks that dropping the enable clears the flag and any capture-selected channel. It also checks that channels ignore the select bit outside free-running mode, where a wrong design would stop producing matches.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_FREERUN  = 2'd1,
        MODE_PULSEW   = 2'd2,
        MODE_RSVD     = 2'd3
    } tmr_mode_e;

    localparam int OPT_FLAG_BIT = 0;
    localparam int OPT_SEL_BASE = 4;
    localparam int BUS_AW       = 3;

    typedef struct packed {
        logic              en;
        logic [BUS_AW-1:0] addr;
        logic [7:0]        data;
        logic [7:0]        mask;
    } bus_wr_t;

    function automatic logic [7:0] merge_byte(input logic [7:0] old_b,
                                              input logic [7:0] new_b,
                                              input logic [7:0] mask);
        return (old_b & ~mask) | (new_b & mask);
    endfunction

    function automatic logic flag_mode(input tmr_mode_e m);
        return (m == MODE_FREERUN) || (m == MODE_PULSEW);
    endfunction

    function automatic logic capture_active(input logic sel, input tmr_mode_e m);
        return sel && (m == MODE_FREERUN);
    endfunction

endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  tmr_mode_e        mode,
    input  bus_wr_t          wr,
    input  logic [CNT_W-1:0] ccr0,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             irq
);
    localparam int NB       = CNT_W / 8;
    localparam int CNT_BASE = 1 + NUM_CH * NB;

    logic [CNT_W-1:0] cnt_q, cnt_wdata, cnt_d;
    logic             wr_hit;

    always_comb begin
        wr_hit    = 1'b0;
        cnt_wdata = cnt_q;
        for (int b = 0; b < NB; b++) begin
            if (wr.en && wr.addr == BUS_AW'(CNT_BASE + b)) begin
                wr_hit = 1'b1;
                cnt_wdata[b*8 +: 8] = merge_byte(cnt_q[b*8 +: 8], wr.data, wr.mask);
            end
        end
    end

    always_comb begin
        if (!en)                                       cnt_d = '0;
        else if (wr_hit)                               cnt_d = cnt_wdata;
        else if (mode == MODE_INTERVAL && cnt_q == ccr0) cnt_d = '0;
        else                                           cnt_d = cnt_q + 1'b1;
    end

    assign wrap = en && !wr_hit && (cnt_q == {CNT_W{1'b1}}) && flag_mode(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq   <= wrap;
        end
    end

    assign cnt = cnt_q;

    assert_hold_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0);
    assert_irq_single_R3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    assert_irq_mode_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(flag_mode(mode)));

endmodule

// File: rtl/tmr16_optreg.sv
module tmr16_optreg
    import tmr16_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_wr_t           wr,
    input  logic              wrap,
    output logic [NUM_CH-1:0] sel,
    output logic              ovf,
    output logic [7:0]        opt_byte
);
    logic wr_opt, clr_req;

    assign wr_opt  = wr.en && (wr.addr == '0);
    assign clr_req = wr_opt && wr.mask[OPT_FLAG_BIT] && !wr.data[OPT_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            sel <= '0;
        end else begin
            if (!en)          ovf <= 1'b0;
            else if (wrap)    ovf <= 1'b1;
            else if (clr_req) ovf <= 1'b0;
            for (int i = 0; i < NUM_CH; i++) begin
                if (!en && wr_opt && wr.mask[OPT_SEL_BASE+i])
                    sel[i] <= wr.data[OPT_SEL_BASE+i];
            end
        end
    end

    always_comb begin
        opt_byte = 8'h00;
        opt_byte[OPT_FLAG_BIT] = ovf;
        for (int i = 0; i < NUM_CH; i++) opt_byte[OPT_SEL_BASE+i] = sel[i];
    end

    assert_dis_clears_flag_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ovf);
    assert_flag_rise_from_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(wrap));
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf);
    assert_sel_locked_R7: assert property (@(posedge clk) disable iff (rst)
        $past(en) |-> $stable(sel));

endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int IDX    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  tmr_mode_e        mode,
    input  logic             sel,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    input  bus_wr_t          wr,
    output logic [CNT_W-1:0] ccr,
    output logic             match
);
    localparam int NB      = CNT_W / 8;
    localparam int CH_BASE = 1 + IDX * NB;

    logic             cap_q, cap_rise, cap_on;
    logic [CNT_W-1:0] ccr_q, ccr_wdata;
    logic             wr_hit;

    assign cap_on   = capture_active(sel, mode);
    assign cap_rise = cap_in && !cap_q;

    always_comb begin
        wr_hit    = 1'b0;
        ccr_wdata = ccr_q;
        for (int b = 0; b < NB; b++) begin
            if (wr.en && wr.addr == BUS_AW'(CH_BASE + b)) begin
                wr_hit = 1'b1;
                ccr_wdata[b*8 +: 8] = merge_byte(ccr_q[b*8 +: 8], wr.data, wr.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
            cap_q <= 1'b0;
        end else begin
            cap_q <= cap_in;
            if (!en && sel)                   ccr_q <= '0;
            else if (en && cap_on && cap_rise) ccr_q <= cnt;
            else if (wr_hit && !sel)           ccr_q <= ccr_wdata;
        end
    end

    assign ccr   = ccr_q;
    assign match = en && !cap_on && (cnt == ccr_q);

    assert_cap_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && sel) |=> ccr_q == '0);

endmodule

// File: rtl/tmr16_ccsel.sv
module tmr16_ccsel
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic [1:0]        mode_i,
    input  logic [NUM_CH-1:0] capture_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic [7:0]        bus_wmask_i,
    output logic [7:0]        bus_rdata_o,
    output logic [NUM_CH-1:0] match_o,
    output logic              ovf_irq_o
);
    localparam int NB       = CNT_W / 8;
    localparam int CNT_BASE = 1 + NUM_CH * NB;

    tmr_mode_e         mode;
    bus_wr_t           wr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  ccr [NUM_CH];
    logic [NUM_CH-1:0] sel;
    logic              wrap, ovf;
    logic [7:0]        opt_byte;

    assign mode = tmr_mode_e'(mode_i);
    assign wr   = '{en: bus_wr_i, addr: bus_addr_i, data: bus_wdata_i, mask: bus_wmask_i};

    tmr16_counter #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_counter (
        .clk(clk), .rst(rst), .en(enable_i), .mode(mode), .wr(wr),
        .ccr0(ccr[0]), .cnt(cnt), .wrap(wrap), .irq(ovf_irq_o)
    );

    tmr16_optreg #(.NUM_CH(NUM_CH)) u_optreg (
        .clk(clk), .rst(rst), .en(enable_i), .wr(wr), .wrap(wrap),
        .sel(sel), .ovf(ovf), .opt_byte(opt_byte)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr16_channel #(.CNT_W(CNT_W), .IDX(g)) u_ch (
            .clk(clk), .rst(rst), .en(enable_i), .mode(mode), .sel(sel[g]),
            .cap_in(capture_i[g]), .cnt(cnt), .wr(wr),
            .ccr(ccr[g]), .match(match_o[g])
        );
    end

    always_comb begin
        bus_rdata_o = 8'h00;
        if (bus_addr_i == '0) bus_rdata_o = opt_byte;
        for (int c = 0; c < NUM_CH; c++)
            for (int b = 0; b < NB; b++)
                if (bus_addr_i == BUS_AW'(1 + c*NB + b)) bus_rdata_o = ccr[c][b*8 +: 8];
        for (int b = 0; b < NB; b++)
            if (bus_addr_i == BUS_AW'(CNT_BASE + b)) bus_rdata_o = cnt[b*8 +: 8];
    end

    assert_irq_flag_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_irq_o |-> ovf);

endmodule

// File: tb/tmr16_ccsel_bench.sv
module tmr16_ccsel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable_i = 1'b0;
    logic [1:0] mode_i = 2'd1;
    logic [1:0] capture_i = 2'b00;
    logic [2:0] bus_addr_i = 3'd0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_wmask_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic [1:0] match_o;
    logic       ovf_irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr16_ccsel u_tmr16_ccsel (
        .clk(clk), .rst(rst), .enable_i(enable_i), .mode_i(mode_i),
        .capture_i(capture_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .bus_wmask_i(bus_wmask_i),
        .bus_rdata_o(bus_rdata_o), .match_o(match_o), .ovf_irq_o(ovf_irq_o)
    );

    // reference model state
    logic [15:0] m_cnt;
    logic [15:0] m_ccr [2];
    logic [1:0]  m_sel, m_capq;
    logic        m_ovf, m_irq;

    function automatic logic [7:0] mrg(input logic [7:0] o, input logic [7:0] d, input logic [7:0] m);
        return (o & ~m) | (d & m);
    endfunction

    function automatic logic exp_wrap();
        return enable_i && !(bus_wr_i && (bus_addr_i == 3'd5 || bus_addr_i == 3'd6))
               && m_cnt == 16'hFFFF && (mode_i == 2'd1 || mode_i == 2'd2);
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {2'b00, m_sel, 3'b000, m_ovf};
            3'd1: return m_ccr[0][7:0];
            3'd2: return m_ccr[0][15:8];
            3'd3: return m_ccr[1][7:0];
            3'd4: return m_ccr[1][15:8];
            3'd5: return m_cnt[7:0];
            3'd6: return m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_match(input int i);
        return enable_i && !(m_sel[i] && mode_i == 2'd1) && m_cnt == m_ccr[i];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_ccr[0] <= '0; m_ccr[1] <= '0;
            m_sel <= '0; m_capq <= '0; m_ovf <= 1'b0; m_irq <= 1'b0;
        end else begin
            m_irq <= exp_wrap();
            if (!enable_i) m_ovf <= 1'b0;
            else if (exp_wrap()) m_ovf <= 1'b1;
            else if (bus_wr_i && bus_addr_i == 3'd0 && bus_wmask_i[0] && !bus_wdata_i[0]) m_ovf <= 1'b0;
            if (!enable_i) m_cnt <= '0;
            else if (bus_wr_i && bus_addr_i == 3'd5) m_cnt <= {m_cnt[15:8], mrg(m_cnt[7:0], bus_wdata_i, bus_wmask_i)};
            else if (bus_wr_i && bus_addr_i == 3'd6) m_cnt <= {mrg(m_cnt[15:8], bus_wdata_i, bus_wmask_i), m_cnt[7:0]};
            else if (mode_i == 2'd0 && m_cnt == m_ccr[0]) m_cnt <= '0;
            else m_cnt <= m_cnt + 16'd1;
            m_capq <= capture_i;
            for (int i = 0; i < 2; i++) begin
                if (!enable_i && bus_wr_i && bus_addr_i == 3'd0 && bus_wmask_i[4+i])
                    m_sel[i] <= bus_wdata_i[4+i];
                if (!enable_i && m_sel[i]) m_ccr[i] <= '0;
                else if (enable_i && m_sel[i] && mode_i == 2'd1 && capture_i[i] && !m_capq[i]) m_ccr[i] <= m_cnt;
                else if (bus_wr_i && !m_sel[i] && bus_addr_i == 3'(1 + 2*i))
                    m_ccr[i] <= {m_ccr[i][15:8], mrg(m_ccr[i][7:0], bus_wdata_i, bus_wmask_i)};
                else if (bus_wr_i && !m_sel[i] && bus_addr_i == 3'(2 + 2*i))
                    m_ccr[i] <= {mrg(m_ccr[i][15:8], bus_wdata_i, bus_wmask_i), m_ccr[i][7:0]};
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rtag;
        check("R3 irq", ovf_irq_o, m_irq);
        check("R8 match0", match_o[0], exp_match(0));
        check("R8 match1", match_o[1], exp_match(1));
        case (bus_addr_i)
            3'd0: rtag = "R4 option read";
            3'd1, 3'd2, 3'd3, 3'd4: rtag = "R9 channel read";
            default: rtag = "R10 counter read";
        endcase
        check(rtag, bus_rdata_o, exp_read(bus_addr_i));
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
        bus_addr_i = a; bus_wdata_i = d; bus_wmask_i = m; bus_wr_i = 1'b1;
        cyc();
        bus_wr_i = 1'b0;
    endtask

    task automatic run_to_top();
        bus_write(3'd6, 8'hFF, 8'hFF);
        while (m_cnt != 16'hFFFF) cyc();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1 reset state
        bus_addr_i = 3'd0; #1; check("R1 option reset", bus_rdata_o, 8'h00);
        bus_addr_i = 3'd6; #1; check("R1 counter reset", bus_rdata_o, 8'h00);
        bus_addr_i = 3'd2; #1; check("R1 channel reset", bus_rdata_o, 8'h00);
        check("R1 irq reset", ovf_irq_o, 1'b0);
        check("R1 match reset", match_o, 2'b00);

        // R2 / R5 / R7: write all ones while disabled
        bus_write(3'd0, 8'hFF, 8'hFF);
        bus_addr_i = 3'd0; #1; check("R2 R5 R7 option after FF", bus_rdata_o, 8'h30);
        bus_write(3'd0, 8'h00, 8'h20);
        #1; check("R7 clear sel1 only", bus_rdata_o, 8'h10);

        // R7 locked while enabled
        enable_i = 1'b1; mode_i = 2'd1;
        cyc();
        bus_write(3'd0, 8'h20, 8'h30);
        bus_addr_i = 3'd0; #1; check("R7 locked sel", bus_rdata_o, 8'h10);

        // R9 capture in free-running mode
        repeat (5) cyc();
        capture_i = 2'b01; cyc(); capture_i = 2'b00;
        repeat (3) cyc();
        bus_addr_i = 3'd1; #1; check("R9 capture low byte", bus_rdata_o, m_ccr[0][7:0]);
        check("R9 captured nonzero", (m_ccr[0] != 0), 1'b1);
        bus_write(3'd1, 8'hAA, 8'hFF);
        bus_addr_i = 3'd1; #1; check("R9 write ignored on capture channel", bus_rdata_o, m_ccr[0][7:0]);

        // R3 wrap in free-running mode
        run_to_top();
        cyc();
        check("R3 irq at wrap", ovf_irq_o, 1'b1);
        bus_addr_i = 3'd0; #1; check("R3 flag at wrap", bus_rdata_o[0], 1'b1);
        cyc();
        check("R3 irq single cycle", ovf_irq_o, 1'b0);
        repeat (3) cyc();
        check("R4 read does not clear", bus_rdata_o[0], 1'b1);
        bus_write(3'd0, 8'h01, 8'h01);
        bus_addr_i = 3'd0; #1; check("R5 write one keeps flag", bus_rdata_o[0], 1'b1);
        bus_write(3'd0, 8'h00, 8'h01);
        bus_addr_i = 3'd0; #1; check("R4 write zero clears", bus_rdata_o, 8'h10);

        // R6 set beats clear on same edge
        run_to_top();
        bus_write(3'd0, 8'h00, 8'h01);
        bus_addr_i = 3'd0; #1; check("R6 set wins", bus_rdata_o[0], 1'b1);

        // R4 / R9 disable clears flag and captured channel
        enable_i = 1'b0; cyc();
        bus_addr_i = 3'd0; #1; check("R4 disable clears flag", bus_rdata_o, 8'h10);
        bus_addr_i = 3'd1; #1; check("R9 disable clears capture", bus_rdata_o, 8'h00);
        bus_write(3'd0, 8'h00, 8'h30);

        // R3 interval mode: wrap without flag; R10 interval restart
        bus_write(3'd1, 8'h34, 8'hFF);
        bus_write(3'd2, 8'h12, 8'hFF);
        enable_i = 1'b1; mode_i = 2'd0;
        cyc();
        run_to_top();
        cyc();
        check("R3 no irq in interval", ovf_irq_o, 1'b0);
        bus_addr_i = 3'd0; #1; check("R3 no flag in interval", bus_rdata_o[0], 1'b0);
        while (m_cnt != 16'h1234) cyc();
        check("R8 match at ch0 value", match_o[0], 1'b1);
        cyc();
        bus_addr_i = 3'd6; #1; check("R10 interval restart", bus_rdata_o, 8'h00);

        // R3 pulse-width mode sets flag
        mode_i = 2'd2;
        run_to_top();
        cyc();
        check("R3 irq in pulse-width", ovf_irq_o, 1'b1);

        // R9 select ignored outside free-running
        enable_i = 1'b0; cyc();
        bus_write(3'd0, 8'h20, 8'h20);
        enable_i = 1'b1; mode_i = 2'd3; cyc();
        while (m_cnt != m_ccr[1]) cyc();
        check("R9 sel ignored mode 3 gives match", match_o[1], 1'b1);

        // constrained random phase
        for (int n = 0; n < 6000; n++) begin
            bus_wr_i    = ($urandom % 6) == 0;
            bus_addr_i  = 3'($urandom % 8);
            bus_wdata_i = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
            bus_wmask_i = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            capture_i   = 2'($urandom);
            if (($urandom % 150) == 0) enable_i = ~enable_i;
            if (($urandom % 300) == 0) mode_i = 2'($urandom);
            cyc();
        end
        bus_wr_i = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule